// File: doc/BRIEF.md
# Command Word Legality Checker

This block sits behind the word decoder of a serial avionics bus remote terminal. It takes each 16-bit command word as the decoder delivers it and reaches a verdict. The command may be for another terminal and therefore ignored. It may be addressed to this terminal and accepted. It may be addressed to this terminal and refused as illegal. The verdict decides whether the terminal responds in form or raises the message-error condition in its status word. It also gives downstream storage logic the number of data words to expect.

Legality comes from a 4096-bit table kept in a local RAM. The table has one bit for every combination of broadcast versus directed, transmit versus receive, subaddress, and word count or mode code, and a host port writes it one 16-bit word at a time. The terminal's own address comes from five strap pins plus an odd-parity pin. Legality checking can be switched off, and so can broadcast recognition. When broadcast is recognized, a separate flag lets the buffer logic keep broadcast data apart from directed data.

Top module: `cmd_legality_chk`

## Requirements
- R1: The command word is split as terminal address [15:11], transmit/receive [10], subaddress [9:5] and count/mode [4:0]. `mode_cmd_o` is 1 exactly when the subaddress is 0 or 31.
- R2: A command whose address is not 31 and equals `rt_addr_i` is addressed (`addr_match_o`=1, `bcast_o`=0) only if `{rt_addr_i, rt_addr_par_i}` has an odd number of ones. With a parity error, every directed command is ignored.
- R3: Address 31 is broadcast. With `cfg_bcast_en_i`=1 it is addressed with `bcast_o`=1, whatever the address parity. With `cfg_bcast_en_i`=0 it is ignored, and `addr_match_o`, `bcast_o`, `legal_o`, `msg_err_o` and `word_cnt_o` are all 0.
- R4: The table index is {broadcast recognized, T/R, subaddress, count/mode} (12 bits). Table word `index[11:4]` holds the entry in bit `index[3:0]`, and a set bit means illegal. A host write stores `tbl_wdata_i` at word `tbl_addr_i` when `tbl_we_i`=1.
- R5: With checking enabled, an addressed command whose table bit is set gives `legal_o`=0 and `msg_err_o`=1. An addressed command whose bit is clear gives `legal_o`=1 and `msg_err_o`=0. An ignored command gives 0 on both.
- R6: With `cfg_check_en_i`=0, every addressed command gives `legal_o`=1 and `msg_err_o`=0, whatever the table holds.
- R7: `word_cnt_o` gives the expected data word count for a legal command. For a non-mode command it is the count field, with 0 meaning 32. For a mode command it is the value of bit 4 of the mode code (0 or 1). For an illegal or ignored command it is 0.
- R8: A command presented with `cmd_valid_i` at clock edge E, with no table write, gives `res_valid_o`=1 for exactly the cycle after E. The result outputs keep their values until the next result.
- R9: A table write in the same cycle as a pending lookup delays that lookup by one cycle, and the lookup then sees the written data. If a new command arrives during the delayed cycle, the newest command is the one looked up.
- R10: After reset, `res_valid_o`, `addr_match_o`, `bcast_o`, `mode_cmd_o`, `legal_o`, `msg_err_o` and `word_cnt_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_check_en_i | input | 1 | Enable legality checking |
| cfg_bcast_en_i | input | 1 | Enable broadcast recognition |
| rt_addr_i | input | 5 | Own terminal address straps |
| rt_addr_par_i | input | 1 | Odd parity bit for the address straps |
| cmd_valid_i | input | 1 | Command word strobe |
| cmd_word_i | input | 16 | Received command word |
| tbl_we_i | input | 1 | Table write enable |
| tbl_addr_i | input | 8 | Table word address |
| tbl_wdata_i | input | 16 | Table write data |
| res_valid_o | output | 1 | One-cycle verdict strobe |
| addr_match_o | output | 1 | Command is addressed to this terminal |
| bcast_o | output | 1 | Command is a recognized broadcast |
| mode_cmd_o | output | 1 | Command is a mode command |
| legal_o | output | 1 | Addressed and legal |
| msg_err_o | output | 1 | Addressed and illegal; feeds the status word message-error bit |
| word_cnt_o | output | 6 | Expected data word count |

## Verification
A wrong table bit or a wrong index mapping shows at the ports as a flipped `legal_o`/`msg_err_o` pair on the very next strobe for the affected combination. The bench therefore places illegal entries on neighbours that differ only in T/R, broadcast or subaddress. If the hold register from a collided lookup is lost, or if it is not replaced by a newer command, the strobe goes missing or carries the wrong count one cycle after the write. A mis-decoded address or parity shows at once as `addr_match_o` on commands meant for another terminal.

// File: rtl/cmd_chk_pkg.sv
package cmd_chk_pkg;
  localparam int TA_W   = 5;
  localparam int SA_W   = 5;
  localparam int WC_W   = 5;
  localparam int CMD_W  = TA_W + 1 + SA_W + WC_W;
  localparam int IDX_W  = 2 + SA_W + WC_W;
  localparam int TBL_DW = 16;
  localparam int BIT_W  = $clog2(TBL_DW);
  localparam int TBL_AW = IDX_W - BIT_W;
  localparam int CNT_W  = WC_W + 1;

  typedef struct packed {
    logic [TA_W-1:0] ta;
    logic            tr;
    logic [SA_W-1:0] sa;
    logic [WC_W-1:0] wc;
  } cmd_t;

  typedef struct packed {
    logic             match;
    logic             bcast;
    logic             mode;
    logic [IDX_W-1:0] idx;
    logic [CNT_W-1:0] cnt;
  } dec_t;
endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
  import cmd_chk_pkg::*;
(
  input  cmd_t            cmd_i,
  input  logic [TA_W-1:0] rt_addr_i,
  input  logic            rt_addr_par_i,
  input  logic            bcast_en_i,
  output dec_t            dec_o
);
  logic bc_addr, par_ok, dir_hit, bc_hit, mode;

  always_comb begin
    bc_addr = &cmd_i.ta;
    par_ok  = ^{rt_addr_i, rt_addr_par_i};
    dir_hit = !bc_addr && par_ok && (cmd_i.ta == rt_addr_i);
    bc_hit  = bc_addr && bcast_en_i;
    mode    = (cmd_i.sa == '0) || (&cmd_i.sa);

    dec_o.match = dir_hit | bc_hit;
    dec_o.bcast = bc_hit;
    dec_o.mode  = mode;
    dec_o.idx   = {bc_hit, cmd_i.tr, cmd_i.sa, cmd_i.wc};
    if (mode)
      dec_o.cnt = CNT_W'(cmd_i.wc[WC_W-1]);
    else
      dec_o.cnt = {(cmd_i.wc == '0), cmd_i.wc};
  end
endmodule

// File: rtl/illeg_table.sv
module illeg_table
  import cmd_chk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [TBL_AW-1:0] waddr_i,
  input  logic [TBL_DW-1:0] wdata_i,
  input  logic              re_i,
  input  logic [TBL_AW-1:0] raddr_i,
  output logic [TBL_DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << TBL_AW;

  logic [TBL_DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem[raddr_i];
  end

  // single-port discipline: controller must never read in a write cycle
  assert_port_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && re_i));
endmodule

// File: rtl/lookup_ctrl.sv
module lookup_ctrl
  import cmd_chk_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_valid_i,
  input  cmd_t cmd_i,
  input  logic tbl_we_i,
  output logic go_o,
  output cmd_t cmd_o
);
  logic hold_v_q;
  cmd_t hold_q;
  logic req;

  always_comb begin
    req   = cmd_valid_i | hold_v_q;
    cmd_o = cmd_valid_i ? cmd_i : hold_q;
    go_o  = req & !tbl_we_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_v_q <= 1'b0;
      hold_q   <= '0;
    end else begin
      hold_v_q <= req & tbl_we_i;
      if (req & tbl_we_i) hold_q <= cmd_o;
    end
  end

  assert_no_lost_cmd_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && tbl_we_i) |=> (go_o || tbl_we_i || cmd_valid_i));
endmodule

// File: rtl/cmd_legality_chk.sv
module cmd_legality_chk
  import cmd_chk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_check_en_i,
  input  logic              cfg_bcast_en_i,
  input  logic [4:0]        rt_addr_i,
  input  logic              rt_addr_par_i,
  input  logic              cmd_valid_i,
  input  logic [15:0]       cmd_word_i,
  input  logic              tbl_we_i,
  input  logic [7:0]        tbl_addr_i,
  input  logic [15:0]       tbl_wdata_i,
  output logic              res_valid_o,
  output logic              addr_match_o,
  output logic              bcast_o,
  output logic              mode_cmd_o,
  output logic              legal_o,
  output logic              msg_err_o,
  output logic [5:0]        word_cnt_o
);
  logic              go;
  cmd_t              cmd_sel;
  dec_t              dec;
  logic [TBL_DW-1:0] rdata;

  logic              val_q, match_q, bcast_q, mode_q, chk_q;
  logic [BIT_W-1:0]  bit_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              illegal;

  lookup_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_valid_i(cmd_valid_i),
    .cmd_i      (cmd_t'(cmd_word_i)),
    .tbl_we_i   (tbl_we_i),
    .go_o       (go),
    .cmd_o      (cmd_sel)
  );

  cmd_decode u_dec (
    .cmd_i        (cmd_sel),
    .rt_addr_i    (rt_addr_i),
    .rt_addr_par_i(rt_addr_par_i),
    .bcast_en_i   (cfg_bcast_en_i),
    .dec_o        (dec)
  );

  illeg_table u_tbl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (tbl_we_i),
    .waddr_i(tbl_addr_i),
    .wdata_i(tbl_wdata_i),
    .re_i   (go),
    .raddr_i(dec.idx[IDX_W-1:BIT_W]),
    .rdata_o(rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q   <= 1'b0;
      match_q <= 1'b0;
      bcast_q <= 1'b0;
      mode_q  <= 1'b0;
      chk_q   <= 1'b0;
      bit_q   <= '0;
      cnt_q   <= '0;
    end else begin
      val_q <= go;
      if (go) begin
        match_q <= dec.match;
        bcast_q <= dec.bcast;
        mode_q  <= dec.mode;
        chk_q   <= cfg_check_en_i;
        bit_q   <= dec.idx[BIT_W-1:0];
        cnt_q   <= dec.cnt;
      end
    end
  end

  always_comb begin
    illegal      = chk_q & rdata[bit_q];
    res_valid_o  = val_q;
    addr_match_o = match_q;
    bcast_o      = bcast_q;
    mode_cmd_o   = mode_q;
    legal_o      = match_q & !illegal;
    msg_err_o    = match_q & illegal;
    word_cnt_o   = legal_o ? cnt_q : '0;
  end

  assert_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !tbl_we_i) |=> res_valid_o);
  assert_stall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && tbl_we_i) |=> !res_valid_o);
  assert_nochk_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go && !cfg_check_en_i) |=> !msg_err_o);
  assert_bc_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go && !cfg_bcast_en_i && (&cmd_sel.ta)) |=> (!addr_match_o && !bcast_o));
  assert_par_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go && !(^{rt_addr_i, rt_addr_par_i}) && !(&cmd_sel.ta)) |=> !addr_match_o);
  assert_err_cnt_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !legal_o) |-> (word_cnt_o == '0));
endmodule

// File: tb/cmd_legality_chk_test.sv
module cmd_legality_chk_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce = 1'b1, be = 1'b1;
  logic [4:0] rt = 5'd5;
  logic par = 1'b1;
  logic cv = 1'b0;
  logic [15:0] cw = '0;
  logic we = 1'b0;
  logic [7:0] wa = '0;
  logic [15:0] wd = '0;
  logic rv, am, bc, md, lg, er;
  logic [5:0] wc;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cmd_legality_chk uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_check_en_i(ce), .cfg_bcast_en_i(be),
    .rt_addr_i(rt), .rt_addr_par_i(par), .cmd_valid_i(cv), .cmd_word_i(cw),
    .tbl_we_i(we), .tbl_addr_i(wa), .tbl_wdata_i(wd),
    .res_valid_o(rv), .addr_match_o(am), .bcast_o(bc), .mode_cmd_o(md),
    .legal_o(lg), .msg_err_o(er), .word_cnt_o(wc)
  );

  // {ce, be, cmd[15:0], match, bcast, mode, legal, err, wc[5:0]}
  localparam int NV = 13;
  localparam logic [28:0] VEC [NV] = '{
    {2'b11, 5'd5,  1'b1, 5'd3,  5'd4,  5'b10001, 6'd0},  // R4 R5 illegal directed
    {2'b11, 5'd5,  1'b0, 5'd3,  5'd4,  5'b10010, 6'd4},  // R4 T/R neighbour legal
    {2'b11, 5'd5,  1'b1, 5'd3,  5'd0,  5'b10010, 6'd32}, // R7 zero means 32
    {2'b11, 5'd6,  1'b1, 5'd3,  5'd4,  5'b00000, 6'd0},  // R2 other address
    {2'b11, 5'd31, 1'b0, 5'd2,  5'd0,  5'b11001, 6'd0},  // R3 R4 broadcast illegal
    {2'b11, 5'd31, 1'b0, 5'd2,  5'd7,  5'b11010, 6'd7},  // R3 broadcast legal
    {2'b10, 5'd31, 1'b0, 5'd2,  5'd0,  5'b00000, 6'd0},  // R3 broadcast off
    {2'b11, 5'd5,  1'b0, 5'd2,  5'd0,  5'b10010, 6'd32}, // R4 directed twin legal
    {2'b11, 5'd5,  1'b1, 5'd0,  5'd2,  5'b10101, 6'd0},  // R1 R5 mode illegal
    {2'b11, 5'd5,  1'b1, 5'd31, 5'd2,  5'b10110, 6'd0},  // R1 R7 mode, no data
    {2'b11, 5'd5,  1'b0, 5'd31, 5'd17, 5'b10110, 6'd1},  // R7 mode with data
    {2'b01, 5'd5,  1'b1, 5'd3,  5'd4,  5'b10010, 6'd4},  // R6 checking off
    {2'b01, 5'd31, 1'b0, 5'd2,  5'd0,  5'b11010, 6'd32}  // R6 broadcast, checking off
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [11:0] outs();
    return {rv, am, bc, md, lg, er, wc};
  endfunction

  task automatic issue(input logic [15:0] c);
    @(negedge clk);
    cv = 1'b1; cw = c;
    @(negedge clk);
    cv = 1'b0;
  endtask

  task automatic twrite(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; wa = a; wd = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 in reset", 32'(outs()), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 after reset", 32'(outs()), 32'h0);

    for (int i = 0; i < 256; i++) twrite(8'(i), 16'h0);
    twrite(8'h46, 16'h0010); // directed T sa3 wc4
    twrite(8'h84, 16'h0001); // broadcast R sa2 wc0
    twrite(8'h40, 16'h0004); // directed T mode sa0 code2

    for (int v = 0; v < NV; v++) begin
      ce = VEC[v][28];
      be = VEC[v][27];
      issue(VEC[v][26:11]);
      check($sformatf("R1-vector %0d", v), 32'(outs()), {20'h0, 1'b1, VEC[v][10:0]});
    end

    // R8: strobe drops, results hold
    ce = 1'b1; be = 1'b1;
    issue({5'd5, 1'b0, 5'd3, 5'd4});
    check("R8 strobe", 32'(outs()), {20'h0, 12'b1_10010_000100});
    @(negedge clk);
    check("R8 hold", 32'(outs()), {20'h0, 12'b0_10010_000100});

    // R2: parity error ignores directed, broadcast still accepted
    par = 1'b0;
    issue({5'd5, 1'b0, 5'd3, 5'd4});
    check("R2 parity directed", 32'(outs()), {20'h0, 12'b1_00000_000000});
    issue({5'd31, 1'b0, 5'd2, 5'd7});
    check("R3 parity broadcast", 32'(outs()), {20'h0, 12'b1_11010_000111});
    par = 1'b1;

    // R9: collision delays lookup, sees new data
    @(negedge clk);
    cv = 1'b1; cw = {5'd5, 1'b0, 5'd3, 5'd4};
    we = 1'b1; wa = 8'h06; wd = 16'h0010;
    @(negedge clk);
    cv = 1'b0; we = 1'b0;
    check("R9 stalled", 32'(rv), 32'h0);
    @(negedge clk);
    check("R9 delayed verdict", 32'(outs()), {20'h0, 12'b1_10001_000000});
    @(negedge clk);
    check("R9 single strobe", 32'(rv), 32'h0);

    // R9: newest command wins during the delayed cycle
    cv = 1'b1; cw = {5'd5, 1'b0, 5'd3, 5'd4};
    we = 1'b1; wa = 8'h06; wd = 16'h0000;
    @(negedge clk);
    we = 1'b0; cw = {5'd5, 1'b1, 5'd3, 5'd0};
    @(negedge clk);
    cv = 1'b0;
    check("R9 newest wins", 32'(outs()), {20'h0, 12'b1_10010_100000});
    issue({5'd5, 1'b0, 5'd3, 5'd4});
    check("R4 restored entry", 32'(outs()), {20'h0, 12'b1_10010_000100});

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule